// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block holds the transmit and receive byte queues of a serial peripheral controller, together with the registers software uses to watch and steer them. The host side pushes outgoing bytes into the transmit queue and drains incoming bytes from the receive queue. The shift engine does the opposite on each queue. The engine also reports two pulses: the end of a transfer and the release of the chip select.

Software sees four 32-bit registers through a simple write strobe and a combinational read port. The queue-control register holds the two trigger levels and two self-clearing flush commands. The queue-status register packs the two byte counts. The interrupt enable register and the interrupt status register hold one bit per condition, and the status register is cleared by writing ones.

Every condition is recorded in the status register whether or not it is enabled. A single level interrupt line is raised while any status bit is set together with its enable bit. Status bits come in two kinds. Level bits report queue occupancy and come back one cycle after they are cleared if their condition still holds. Event bits report drops, misses and engine pulses, and they stay set until software clears them.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: Each queue holds 64 bytes and returns them first-in first-out; register select 3 reads the transmit byte count in bits 23:16 and the receive byte count in bits 7:0, with all other bits zero.
- R2: Register select 0 is interrupt enable, 1 is interrupt status, 2 is queue control, 3 is queue status; only enable bits 0-2, 4-6 and 8-13 are writable (a write of all ones reads back 0x00003F77).
- R3: Writing 1 to an interrupt status bit (select 1) clears it at the next edge; writing 0 leaves it unchanged.
- R4: Writing 1 to queue-control bit 31 flushes the transmit queue, and writing 1 to bit 15 flushes the receive queue. Each bit reads 1 for the one cycle after the write, then reads 0, and by then the queue's count is zero.
- R5: Queue-control bits 23:16 hold the transmit trigger and bits 7:0 hold the receive trigger, both reading back as written. Status bit 0 sets when the receive count is at or above its trigger. Status bit 4 sets when the transmit count is at or below its trigger.
- R6: A push into a full queue drops the byte and leaves the count at 64. It sets status bit 10 for the transmit queue or bit 8 for the receive queue, at the edge of the push.
- R7: A pop from an empty queue returns zero. It sets status bit 11 for the transmit queue or bit 9 for the receive queue.
- R8: Status bit 1 is set by an empty receive queue and bit 2 by a full one. Bit 5 is set by an empty transmit queue and bit 6 by a full one. Each of these bits is set one edge after its condition appears.
- R9: A transfer-done pulse sets status bit 12 and a chip-select-release pulse sets bit 13. Each bit is set at the edge of its pulse, and a pulse wins over a clear written in the same cycle.
- R10: When a clear and a still-true level condition meet at one edge, the clear wins and the bit reads 0. The bit is set again at the next edge.
- R11: Status bits set regardless of the enable register; the interrupt output is high exactly when some status bit and its enable bit are both 1.
- R12: During reset, all registers, both counts and the interrupt output read zero. At the first edge after reset, status holds 0x33 (both queues empty and both requests true).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| txPush | input | 1 | Host pushes a byte into the transmit queue |
| txPushData | input | 8 | Byte to push into the transmit queue |
| txPop | input | 1 | Shift engine takes a byte from the transmit queue |
| txPopData | output | 8 | Head of the transmit queue, zero when empty |
| rxPush | input | 1 | Shift engine pushes a received byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Host takes a byte from the receive queue |
| rxPopData | output | 8 | Head of the receive queue, zero when empty |
| xferDone | input | 1 | Transfer-complete pulse from the shift engine |
| csRelease | input | 1 | Chip-select-release pulse from the shift engine |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong pointer or count shows up at the queue-status register in the same cycle as the push or pop that corrupts it. It also shows up in the byte order on the pop data ports, and a wrap error appears as soon as a full queue is drained. A status bit that is wrongly kept, lost or set shows up on the status read and on the interrupt line at the next edge. Level bits are checked by clearing them and reading in the next two cycles. Flush and overflow errors show up in the count within one cycle of the command or the extra push.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  localparam int REG_W   = 32;
  localparam int FIELD_W = 8;

  localparam logic [1:0] SEL_IE    = 2'd0;
  localparam logic [1:0] SEL_IS    = 2'd1;
  localparam logic [1:0] SEL_FCTL  = 2'd2;
  localparam logic [1:0] SEL_FSTAT = 2'd3;

  localparam int BIT_RX_REQ   = 0;
  localparam int BIT_RX_EMPTY = 1;
  localparam int BIT_RX_FULL  = 2;
  localparam int BIT_TX_REQ   = 4;
  localparam int BIT_TX_EMPTY = 5;
  localparam int BIT_TX_FULL  = 6;
  localparam int BIT_RX_OVF   = 8;
  localparam int BIT_RX_UDR   = 9;
  localparam int BIT_TX_OVF   = 10;
  localparam int BIT_TX_UDR   = 11;
  localparam int BIT_DONE     = 12;
  localparam int BIT_CS_REL   = 13;

  localparam int FCTL_TX_FLUSH = 31;
  localparam int FCTL_RX_FLUSH = 15;
  localparam int FCTL_TX_TRIG  = 16;
  localparam int FCTL_RX_TRIG  = 0;
  localparam int FSTAT_TX_CNT  = 16;
  localparam int FSTAT_RX_CNT  = 0;

  localparam logic [REG_W-1:0] LEVEL_MASK =
    (REG_W'(1) << BIT_RX_REQ) | (REG_W'(1) << BIT_RX_EMPTY) | (REG_W'(1) << BIT_RX_FULL) |
    (REG_W'(1) << BIT_TX_REQ) | (REG_W'(1) << BIT_TX_EMPTY) | (REG_W'(1) << BIT_TX_FULL);
  localparam logic [REG_W-1:0] EVENT_MASK =
    (REG_W'(1) << BIT_RX_OVF) | (REG_W'(1) << BIT_RX_UDR) | (REG_W'(1) << BIT_TX_OVF) |
    (REG_W'(1) << BIT_TX_UDR) | (REG_W'(1) << BIT_DONE)   | (REG_W'(1) << BIT_CS_REL);
  localparam logic [REG_W-1:0] IRQ_MASK = LEVEL_MASK | EVENT_MASK;

  // Strobes from control to datapath
  typedef struct packed {
    logic txFlush;
    logic rxFlush;
  } fifoCtrlT;

  // Single-cycle error events from datapath to control
  typedef struct packed {
    logic txOvf;
    logic txUdr;
    logic rxOvf;
    logic rxUdr;
  } fifoEvtT;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             underrun
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isEmpty, popOk, pushOk;

  assign isEmpty  = (count == '0);
  assign popOk    = pop && !isEmpty;
  assign pushOk   = push && ((count != FULL_CNT) || popOk);
  assign overflow = push && !pushOk;
  assign underrun = pop && isEmpty;
  assign popData  = isEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_datapath.sv
module spi_fifo_datapath
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtrlT         ctrl,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output fifoEvtT          evt
);

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctrl.txFlush),
    .push     (txPush),
    .pushData (txPushData),
    .pop      (txPop),
    .popData  (txPopData),
    .count    (txCount),
    .overflow (evt.txOvf),
    .underrun (evt.txUdr)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctrl.rxFlush),
    .push     (rxPush),
    .pushData (rxPushData),
    .pop      (rxPop),
    .popData  (rxPopData),
    .count    (rxCount),
    .overflow (evt.rxOvf),
    .underrun (evt.rxUdr)
  );

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  fifoEvtT          evt,
  input  logic             xferDone,
  input  logic             csRelease,
  output fifoCtrlT         ctrl,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] enable,
  output logic             irq
);

  localparam logic [FIELD_W-1:0] FULL_LVL = FIELD_W'(DEPTH);

  logic [FIELD_W-1:0] txTrig, rxTrig, txCnt, rxCnt;
  logic [REG_W-1:0]   levelSet, eventSet, clrVec, statusNext;
  logic               wrIe, wrIs, wrFctl;
  logic               txFlushPend, rxFlushPend;

  assign txCnt  = FIELD_W'(txCount);
  assign rxCnt  = FIELD_W'(rxCount);
  assign wrIe   = regWr && (regAddr == SEL_IE);
  assign wrIs   = regWr && (regAddr == SEL_IS);
  assign wrFctl = regWr && (regAddr == SEL_FCTL);

  always_comb begin
    levelSet = '0;
    levelSet[BIT_RX_REQ]   = (rxCnt >= rxTrig);
    levelSet[BIT_RX_EMPTY] = (rxCnt == '0);
    levelSet[BIT_RX_FULL]  = (rxCnt == FULL_LVL);
    levelSet[BIT_TX_REQ]   = (txCnt <= txTrig);
    levelSet[BIT_TX_EMPTY] = (txCnt == '0);
    levelSet[BIT_TX_FULL]  = (txCnt == FULL_LVL);
  end

  always_comb begin
    eventSet = '0;
    eventSet[BIT_RX_OVF] = evt.rxOvf;
    eventSet[BIT_RX_UDR] = evt.rxUdr;
    eventSet[BIT_TX_OVF] = evt.txOvf;
    eventSet[BIT_TX_UDR] = evt.txUdr;
    eventSet[BIT_DONE]   = xferDone;
    eventSet[BIT_CS_REL] = csRelease;
  end

  // Clear beats a level condition; an event beats a clear
  assign clrVec     = wrIs ? (regWrData & IRQ_MASK) : '0;
  assign statusNext = (((status | levelSet) & ~clrVec) | eventSet) & IRQ_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status      <= '0;
      enable      <= '0;
      txTrig      <= '0;
      rxTrig      <= '0;
      txFlushPend <= 1'b0;
      rxFlushPend <= 1'b0;
    end else begin
      status      <= statusNext;
      txFlushPend <= wrFctl && regWrData[FCTL_TX_FLUSH];
      rxFlushPend <= wrFctl && regWrData[FCTL_RX_FLUSH];
      if (wrIe) enable <= regWrData & IRQ_MASK;
      if (wrFctl) begin
        txTrig <= regWrData[FCTL_TX_TRIG +: FIELD_W];
        rxTrig <= regWrData[FCTL_RX_TRIG +: FIELD_W];
      end
    end
  end

  assign ctrl.txFlush = txFlushPend;
  assign ctrl.rxFlush = rxFlushPend;
  assign irq          = |(status & enable);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      SEL_IE: regRdData = enable;
      SEL_IS: regRdData = status;
      SEL_FCTL: begin
        regRdData[FCTL_TX_FLUSH]              = txFlushPend;
        regRdData[FCTL_RX_FLUSH]              = rxFlushPend;
        regRdData[FCTL_TX_TRIG +: FIELD_W]    = txTrig;
        regRdData[FCTL_RX_TRIG +: FIELD_W]    = rxTrig;
      end
      default: begin
        regRdData[FSTAT_TX_CNT +: FIELD_W] = txCnt;
        regRdData[FSTAT_RX_CNT +: FIELD_W] = rxCnt;
      end
    endcase
  end

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  input  logic             xferDone,
  input  logic             csRelease,
  output logic             irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCtrlT         ctrl;
  fifoEvtT          evt;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [REG_W-1:0] status, enable;

  spi_fifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .txPush     (txPush),
    .txPushData (txPushData),
    .txPop      (txPop),
    .txPopData  (txPopData),
    .rxPush     (rxPush),
    .rxPushData (rxPushData),
    .rxPop      (rxPop),
    .rxPopData  (rxPopData),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .evt        (evt)
  );

  spi_irq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .evt       (evt),
    .xferDone  (xferDone),
    .csRelease (csRelease),
    .ctrl      (ctrl),
    .status    (status),
    .enable    (enable),
    .irq       (irq)
  );

endmodule

// File: rtl/spi_fifo_irq_sva.sv
module spi_fifo_irq_sva
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             txPush,
  input logic             txPop,
  input logic             rxPop,
  input logic [WIDTH-1:0] rxPopData,
  input logic             xferDone,
  input logic             irq,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [REG_W-1:0] status,
  input logic [REG_W-1:0] enable,
  input fifoCtrlT         ctrl
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic unusedBits;
  assign unusedBits = ^{regWrData, status, enable};

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL_CNT) && (rxCount <= FULL_CNT)); // R1

  AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && !txPop && !ctrl.txFlush && txCount == FULL_CNT)
    |=> (txCount == FULL_CNT) && status[BIT_TX_OVF]); // R6

  AST_UDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxPop && rxCount == '0) |-> (rxPopData == '0)); // R7

  AST_UDR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rxPop && rxCount == '0) |=> status[BIT_RX_UDR]); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.txFlush |=> (txCount == '0)); // R4

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rxFlush && !(regWr && regAddr == SEL_FCTL && regWrData[FCTL_RX_FLUSH]))
    |=> !ctrl.rxFlush); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == SEL_IS && regWrData[BIT_DONE] && !xferDone)
    |=> !status[BIT_DONE]); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> status[BIT_DONE]); // R9

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (status[BIT_DONE] && enable[BIT_DONE]) |-> irq); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enable == '0) |-> !irq); // R11

endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_sva #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .txPush    (txPush),
  .txPop     (txPop),
  .rxPop     (rxPop),
  .rxPopData (rxPopData),
  .xferDone  (xferDone),
  .irq       (irq),
  .txCount   (txCount),
  .rxCount   (rxCount),
  .status    (status),
  .enable    (enable),
  .ctrl      (ctrl)
);

// File: tb/spi_fifo_irq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_fifo_irq_ctrl_bench;

  localparam logic [3:0] OP_RD = 4'd0, OP_WR = 4'd1, OP_TXP = 4'd2, OP_RXP = 4'd3,
                         OP_TXPOP = 4'd4, OP_RXPOP = 4'd5, OP_IDLE = 4'd6,
                         OP_IRQ = 4'd7, OP_DONE = 4'd8;
  localparam int NVEC = 33;

  // {op, select, data, expected}
  localparam logic [69:0] VEC [NVEC] = '{
    {OP_RD,    2'd3, 32'h0,        32'h0},         // R1 counts empty
    {OP_WR,    2'd2, 32'h00030002, 32'h0},
    {OP_RD,    2'd2, 32'h0,        32'h00030002},  // R5 trigger readback
    {OP_TXP,   2'd0, 32'hA1,       32'h0},
    {OP_TXP,   2'd0, 32'hB2,       32'h0},
    {OP_RD,    2'd3, 32'h0,        32'h00020000},  // R1 tx count field
    {OP_RXP,   2'd0, 32'h11,       32'h0},
    {OP_RXP,   2'd0, 32'h22,       32'h0},
    {OP_RXP,   2'd0, 32'h33,       32'h0},
    {OP_RD,    2'd3, 32'h0,        32'h00020003},  // R1 both counts
    {OP_IDLE,  2'd0, 32'h0,        32'h0},
    {OP_WR,    2'd1, 32'h0,        32'h0},
    {OP_RD,    2'd1, 32'h0,        32'h00000033},  // R3 zero write keeps
    {OP_WR,    2'd1, 32'hFFFFFFFF, 32'h0},
    {OP_RD,    2'd1, 32'h0,        32'h00000000},  // R10 clear wins
    {OP_IDLE,  2'd0, 32'h0,        32'h0},
    {OP_RD,    2'd1, 32'h0,        32'h00000011},  // R10 R5 R8 re-set
    {OP_TXPOP, 2'd0, 32'h0,        32'h000000A1},  // R1 order
    {OP_RXPOP, 2'd0, 32'h0,        32'h00000011},  // R1
    {OP_RXPOP, 2'd0, 32'h0,        32'h00000022},  // R1
    {OP_RD,    2'd3, 32'h0,        32'h00010001},  // R1
    {OP_WR,    2'd0, 32'h00001000, 32'h0},
    {OP_IRQ,   2'd0, 32'h0,        32'h0},         // R11
    {OP_DONE,  2'd0, 32'h0,        32'h0},
    {OP_IRQ,   2'd0, 32'h0,        32'h1},         // R9 R11
    {OP_RD,    2'd1, 32'h0,        32'h00001011},  // R9
    {OP_WR,    2'd1, 32'h00001000, 32'h0},
    {OP_IRQ,   2'd0, 32'h0,        32'h0},         // R3
    {OP_RD,    2'd1, 32'h0,        32'h00000011},  // R3
    {OP_RD,    2'd0, 32'h0,        32'h00001000},  // R2
    {OP_WR,    2'd0, 32'hFFFFFFFF, 32'h0},
    {OP_RD,    2'd0, 32'h0,        32'h00003F77},  // R2 writable mask
    {OP_WR,    2'd0, 32'h0,        32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0]  txPushData = '0, rxPushData = '0, txPopData, rxPopData;
  logic        xferDone = 1'b0, csRelease = 1'b0, irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_ctrl u_spi_fifo_irq_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .txPush(txPush), .txPushData(txPushData), .txPop(txPop),
    .txPopData(txPopData), .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .xferDone(xferDone), .csRelease(csRelease), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    txPush = 1'b1; txPushData = d; tick(); txPush = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d; tick(); rxPush = 1'b0;
  endtask

  task automatic popTx(input string req, input logic [7:0] exp);
    txPop = 1'b1; #1;
    check(req, {24'h0, txPopData}, {24'h0, exp});
    tick(); txPop = 1'b0;
  endtask

  task automatic popRx(input string req, input logic [7:0] exp);
    rxPop = 1'b1; #1;
    check(req, {24'h0, rxPopData}, {24'h0, exp});
    tick(); rxPop = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    // R12 reset state
    repeat (3) @(posedge clk);
    #2;
    rdReg(2'd1, v); check("R12 status in reset", v, 32'h0);
    rdReg(2'd3, v); check("R12 counts in reset", v, 32'h0);
    rdReg(2'd2, v); check("R12 control in reset", v, 32'h0);
    check("R12 irq in reset", {31'h0, irq}, 32'h0);
    rstN = 1'b1;
    rdReg(2'd1, v); check("R12 status before first edge", v, 32'h0);
    tick();
    rdReg(2'd1, v); check("R12 status after first edge", v, 32'h33);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  op;
      logic [1:0]  sel;
      logic [31:0] dat, exp;
      string       tag;
      {op, sel, dat, exp} = VEC[i];
      tag = $sformatf("vector %0d", i);
      case (op)
        OP_RD:    begin rdReg(sel, v); check(tag, v, exp); end
        OP_WR:    wrReg(sel, dat);
        OP_TXP:   pushTx(dat[7:0]);
        OP_RXP:   pushRx(dat[7:0]);
        OP_TXPOP: popTx(tag, exp[7:0]);
        OP_RXPOP: popRx(tag, exp[7:0]);
        OP_IRQ:   check(tag, {31'h0, irq}, exp);
        OP_DONE:  begin xferDone = 1'b1; tick(); xferDone = 1'b0; end
        default:  tick();
      endcase
    end

    // R4 self-clearing flush
    wrReg(2'd2, 32'h80038002);
    rdReg(2'd2, v); check("R4 flush bits visible", v, 32'h80038002);
    tick();
    rdReg(2'd2, v); check("R4 flush bits cleared", v, 32'h00030002);
    rdReg(2'd3, v); check("R4 queues empty", v, 32'h0);

    // R6 R8 R1 transmit fill, overflow, drain
    for (int i = 0; i < 64; i++) pushTx(8'(i));
    rdReg(2'd3, v); check("R1 full tx count", v, 32'h00400000);
    wrReg(2'd1, 32'hFFFFFFFF);
    tick();
    rdReg(2'd1, v); check("R8 R5 full tx level bits", v, 32'h00000042);
    pushTx(8'hEE);
    rdReg(2'd1, v); check("R6 tx overflow flag", v, 32'h00000442);
    rdReg(2'd3, v); check("R6 count held at 64", v, 32'h00400000);
    for (int i = 0; i < 64; i++) popTx("R1 tx drain order", 8'(i));
    popTx("R7 tx underrun data", 8'h00);
    rdReg(2'd1, v); check("R7 tx underrun flag", v & 32'h800, 32'h800);

    // R7 receive underrun
    popRx("R7 rx underrun data", 8'h00);
    rdReg(2'd1, v); check("R7 rx underrun flag", v & 32'h200, 32'h200);

    // R6 receive overflow
    for (int i = 0; i < 65; i++) pushRx(8'(i + 1));
    rdReg(2'd3, v); check("R6 rx count held at 64", v, 32'h00000040);
    rdReg(2'd1, v); check("R6 rx overflow flag", v & 32'h100, 32'h100);
    popRx("R1 rx head after overflow", 8'h01);

    // R11 R9 disabled event still recorded
    wrReg(2'd0, 32'h0);
    wrReg(2'd1, 32'hFFFFFFFF);
    csRelease = 1'b1; tick(); csRelease = 1'b0;
    rdReg(2'd1, v); check("R9 cs release flag", v & 32'h2000, 32'h2000);
    check("R11 irq masked", {31'h0, irq}, 32'h0);
    wrReg(2'd0, 32'h00002000);
    check("R11 irq enabled", {31'h0, irq}, 32'h1);
    wrReg(2'd0, 32'h0);

    // R9 event beats a same-cycle clear
    regWr = 1'b1; regAddr = 2'd1; regWrData = 32'h00001000; xferDone = 1'b1;
    tick();
    regWr = 1'b0; regWrData = '0; xferDone = 1'b0;
    rdReg(2'd1, v); check("R9 event wins over clear", v & 32'h1000, 32'h1000);
    wrReg(2'd1, 32'h00001000);
    rdReg(2'd1, v); check("R3 event cleared", v & 32'h1000, 32'h0);

    summary();
    $finish;
  end

endmodule